// File: doc/BRIEF.md
# Audio Bit Clock and Frame Sync Generator

This block produces the bit clock and the frame sync for one direction of an audio serial port. The bit clock can come from an external pin or from an internal divider. The divider splits a high-frequency master clock by any integer from 1 to 4096. The frame sync can also come from outside. When it is generated internally, it repeats once every frame, and a frame is the slot length times the number of slots. The sync pulse lasts either one bit or one whole slot. The polarity of the bit clock and of the frame sync can each be inverted.

The transmit side and the receive side each use their own instance, with their own master clock and their own configuration. The block drives an output enable for the bit clock pin and one for the frame sync pin. The output enable is asserted whenever that signal is generated internally. The whole block runs on the master clock. An external bit clock is brought into that domain through a two-stage synchronizer, so that it can step the frame counter.

Top module: `audio_bclk_fs_gen`

## Requirements
- R1: `cfgDivCode` holds N-1. For N of 2 or more, the internal bit clock has a period of N master clock cycles. It goes high at the terminal count and stays high for floor(N/2) cycles. Counting master clock edges k from 1 after reset release, the clock is high after edge k when ((k-1) mod N) < floor(N/2).
- R2: With N = 1 (`cfgDivCode` = 0), the internal bit clock equals the master clock. This takes effect from the first edge after reset release.
- R3: A new `cfgDivCode` is loaded only at the divider terminal count. The current period finishes with the old ratio.
- R4: With `cfgBclkExt` = 1, `bclkOut` follows `extBclk` combinationally and `bclkOe` is 0.
- R5: With `cfgBclkInv` = 1, `bclkOut` is the inverse of the selected bit clock.
- R6: The internal frame is (`cfgSlotLenM1`+1)·(`cfgSlotsM1`+1) bit clocks long. Bit index 0 starts at the first bit clock rising edge after reset. After internal edge k, the bit index is floor((k-1)/N) mod frame length.
- R7: With `cfgFsSlotWide` = 0, the internal sync is active at bit index 0 only. With `cfgFsSlotWide` = 1, it is active for bit indices 0 through `cfgSlotLenM1`.
- R8: With `cfgFsInv` = 1, `fsOut` is inverted, so the sync is active low and a frame starts on a falling edge.
- R9: With `cfgFsExt` = 1, `fsOut` follows `extFs` (after the polarity of R8) and `fsOe` is 0.
- R10: With an external bit clock, the frame counter steps on the third master clock edge after a rising edge of `extBclk`.
- R11: During reset, `bclkOut` equals `cfgBclkInv`, `fsOut` equals `cfgFsInv`, and each output enable is the inverse of its external select.
- R12: When a source is internal, its output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | High-frequency master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extBclk | input | 1 | External bit clock pin |
| extFs | input | 1 | External frame sync pin |
| cfgDivCode | input | 12 | Divide ratio minus one |
| cfgBclkExt | input | 1 | 1: bit clock taken from the pin |
| cfgBclkInv | input | 1 | 1: invert the bit clock |
| cfgFsExt | input | 1 | 1: frame sync taken from the pin |
| cfgFsSlotWide | input | 1 | 1: sync lasts one slot, 0: one bit |
| cfgFsInv | input | 1 | 1: frame sync active low |
| cfgSlotLenM1 | input | 5 | Bits per slot minus one |
| cfgSlotsM1 | input | 4 | Slots per frame minus one |
| bclkOut | output | 1 | Bit clock after source select and polarity |
| bclkOe | output | 1 | Bit clock pin output enable |
| fsOut | output | 1 | Frame sync after source select and polarity |
| fsOe | output | 1 | Frame sync pin output enable |

## Verification
The internal bit clock phase and the internal frame sync are registered on the master clock edge that advances the divider. Both are checked 1 ns after each master clock edge k, against the arithmetic formulas of R1, R6 and R7. For N = 1, the bit clock is also checked 1 ns after the falling edge, because it follows the master clock directly. External clock and external sync paths are combinational and are checked 1 ns after the input is driven. A frame step caused by an external clock edge is sampled 1 ns after the third master clock edge that follows it. Divide changes are checked edge by edge against the expected sequence: the old period completes, then the new ratio starts.

// File: rtl/abfg_pkg.sv
package abfg_pkg;
  typedef struct packed {
    logic bitTick;
    logic divPhase;
    logic bypass;
  } clkStrobes_t;
endpackage

// File: rtl/abfg_clk_ctrl.sv
module abfg_clk_ctrl
  import abfg_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk,
  input  logic             rstN,
  input  logic             extBclk,
  input  logic             bclkExt,
  input  logic [DIV_W-1:0] divCode,
  output clkStrobes_t      strobes
);
  localparam int SQ_W = SYNC_STAGES + 1;

  logic [DIV_W-1:0] divCnt, activeDiv, cntNext, divNext;
  logic [DIV_W:0]   halfNext;
  logic             termNow, phaseQ, bypassQ, extRise;
  logic [SQ_W-1:0]  syncQ;

  // synchronizer plus one history stage for edge detect
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SQ_W-2:0], extBclk};
  end
  assign extRise = syncQ[SQ_W-2] & ~syncQ[SQ_W-1];

  assign termNow = (divCnt == activeDiv);

  always_comb begin
    if (termNow) begin
      cntNext = '0;
      divNext = divCode;
    end else begin
      cntNext = divCnt + 1'b1;
      divNext = activeDiv;
    end
    halfNext = ({1'b0, divNext} + 1'b1) >> 1;
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      activeDiv <= '0;
      phaseQ    <= 1'b0;
      bypassQ   <= 1'b0;
    end else begin
      divCnt    <= cntNext;
      activeDiv <= divNext;
      phaseQ    <= ({1'b0, cntNext} < halfNext);
      if (termNow) bypassQ <= (divCode == '0);
    end
  end

  assign strobes.bitTick  = bclkExt ? extRise : termNow;
  assign strobes.divPhase = phaseQ;
  assign strobes.bypass   = bypassQ;

  // R1: the counter restarts after a terminal count
  p_wrap_r1: assert property (@(posedge mclk) disable iff (!rstN)
    termNow |=> (divCnt == '0));
  // R1: a period with N >= 2 opens with the high phase
  p_phase_start_r1: assert property (@(posedge mclk) disable iff (!rstN)
    (divCnt == '0 && activeDiv != '0) |-> phaseQ);
  // R3: the ratio cannot change away from a terminal count
  p_hold_r3: assert property (@(posedge mclk) disable iff (!rstN)
    !termNow |=> $stable(activeDiv));
  // R2: bypass is only selected for a ratio of one
  p_bypass_r2: assert property (@(posedge mclk) disable iff (!rstN)
    bypassQ |-> (activeDiv == '0));
endmodule

// File: rtl/abfg_frame_dp.sv
module abfg_frame_dp
  import abfg_pkg::*;
#(
  parameter int SLOT_W  = 5,
  parameter int SLOTS_W = 4
) (
  input  logic               mclk,
  input  logic               rstN,
  input  clkStrobes_t        strobes,
  input  logic               extBclk,
  input  logic               extFs,
  input  logic               bclkExt,
  input  logic               bclkInv,
  input  logic               fsExt,
  input  logic               fsSlotWide,
  input  logic               fsInv,
  input  logic [SLOT_W-1:0]  slotLenM1,
  input  logic [SLOTS_W-1:0] slotsM1,
  output logic               bclkOut,
  output logic               bclkOe,
  output logic               fsOut,
  output logic               fsOe
);
  localparam int CNT_W = SLOT_W + SLOTS_W;

  logic [CNT_W:0]   frameLen;
  logic [CNT_W-1:0] frameLast, bitCnt, bitNext;
  logic             wrapNow, fsActNext, fsIntQ, bclkInt;

  always_comb begin
    frameLen  = ({{(CNT_W-SLOT_W+1){1'b0}}, slotLenM1} + 1'b1)
              * ({{(CNT_W-SLOTS_W+1){1'b0}}, slotsM1} + 1'b1);
    frameLast = CNT_W'(frameLen - 1'b1);
    wrapNow   = (bitCnt >= frameLast);
    bitNext   = wrapNow ? '0 : bitCnt + 1'b1;
    if (fsSlotWide) fsActNext = (bitNext <= CNT_W'(slotLenM1));
    else            fsActNext = (bitNext == '0);
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '1;
      fsIntQ <= 1'b0;
    end else if (strobes.bitTick) begin
      bitCnt <= bitNext;
      fsIntQ <= fsActNext;
    end
  end

  assign bclkInt = strobes.bypass ? mclk : strobes.divPhase;
  assign bclkOut = (bclkExt ? extBclk : bclkInt) ^ bclkInv;
  assign fsOut   = (fsExt ? extFs : fsIntQ) ^ fsInv;
  assign bclkOe  = ~bclkExt;
  assign fsOe    = ~fsExt;

  // R6: the frame restarts after its last bit
  p_frame_wrap_r6: assert property (@(posedge mclk) disable iff (!rstN)
    (strobes.bitTick && wrapNow) |=> (bitCnt == '0));
  // R6: the bit counter only moves on a bit tick
  p_no_step_r6: assert property (@(posedge mclk) disable iff (!rstN)
    !strobes.bitTick |=> $stable(bitCnt));
  // R7: a one-bit sync covers bit zero only
  p_bit_wide_r7: assert property (@(posedge mclk) disable iff (!rstN)
    (!fsSlotWide && fsIntQ) |-> (bitCnt == '0));
  // R7: a slot-wide sync stays inside the first slot
  p_slot_wide_r7: assert property (@(posedge mclk) disable iff (!rstN)
    (fsSlotWide && fsIntQ) |-> (bitCnt <= CNT_W'(slotLenM1)));
endmodule

// File: rtl/audio_bclk_fs_gen.sv
module audio_bclk_fs_gen
  import abfg_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int SLOT_W  = 5,
  parameter int SLOTS_W = 4
) (
  input  logic               mclk,
  input  logic               rstN,
  input  logic               extBclk,
  input  logic               extFs,
  input  logic [DIV_W-1:0]   cfgDivCode,
  input  logic               cfgBclkExt,
  input  logic               cfgBclkInv,
  input  logic               cfgFsExt,
  input  logic               cfgFsSlotWide,
  input  logic               cfgFsInv,
  input  logic [SLOT_W-1:0]  cfgSlotLenM1,
  input  logic [SLOTS_W-1:0] cfgSlotsM1,
  output logic               bclkOut,
  output logic               bclkOe,
  output logic               fsOut,
  output logic               fsOe
);
  clkStrobes_t strobes;

  abfg_clk_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(2)) ctrl_i (
    .mclk(mclk), .rstN(rstN), .extBclk(extBclk), .bclkExt(cfgBclkExt),
    .divCode(cfgDivCode), .strobes(strobes)
  );

  abfg_frame_dp #(.SLOT_W(SLOT_W), .SLOTS_W(SLOTS_W)) dp_i (
    .mclk(mclk), .rstN(rstN), .strobes(strobes), .extBclk(extBclk),
    .extFs(extFs), .bclkExt(cfgBclkExt), .bclkInv(cfgBclkInv),
    .fsExt(cfgFsExt), .fsSlotWide(cfgFsSlotWide), .fsInv(cfgFsInv),
    .slotLenM1(cfgSlotLenM1), .slotsM1(cfgSlotsM1),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .fsOut(fsOut), .fsOe(fsOe)
  );

  // R12: internal sources always drive their pins
  p_oe_r12: assert property (@(posedge mclk) disable iff (!rstN)
    (!cfgBclkExt |-> bclkOe) and (!cfgFsExt |-> fsOe));
endmodule

// File: tb/audio_bclk_fs_gen_tb_top.sv
module audio_bclk_fs_gen_tb_top;
  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic extBclk = 1'b0, extFs = 1'b0;
  logic [11:0] cfgDivCode = '0;
  logic cfgBclkExt = 0, cfgBclkInv = 0, cfgFsExt = 0, cfgFsSlotWide = 0, cfgFsInv = 0;
  logic [4:0] cfgSlotLenM1 = '0;
  logic [3:0] cfgSlotsM1 = '0;
  logic bclkOut, bclkOe, fsOut, fsOe;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 0;

  always #2 mclk = ~mclk;

  audio_bclk_fs_gen dut_i (
    .mclk(mclk), .rstN(rstN), .extBclk(extBclk), .extFs(extFs),
    .cfgDivCode(cfgDivCode), .cfgBclkExt(cfgBclkExt), .cfgBclkInv(cfgBclkInv),
    .cfgFsExt(cfgFsExt), .cfgFsSlotWide(cfgFsSlotWide), .cfgFsInv(cfgFsInv),
    .cfgSlotLenM1(cfgSlotLenM1), .cfgSlotsM1(cfgSlotsM1),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .fsOut(fsOut), .fsOe(fsOe)
  );

  task automatic check(string tag, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge mclk);
    @(posedge mclk); #1;
    check("R11 bclk in reset", bclkOut, cfgBclkInv);
    check("R11 fs in reset", fsOut, cfgFsInv);
    check("R11 bclkOe in reset", bclkOe, !cfgBclkExt);
    check("R11 fsOe in reset", fsOe, !cfgFsExt);
    @(negedge mclk);
    rstN = 1'b1;
  endtask

  task automatic runInternal(int n, int slotLen, int slots, bit wide, bit bInv, bit fInv);
    int frame;
    int total;
    frame = slotLen * slots;
    cfgDivCode = 12'(n - 1);
    cfgSlotLenM1 = 5'(slotLen - 1);
    cfgSlotsM1 = 4'(slots - 1);
    cfgFsSlotWide = wide; cfgBclkInv = bInv; cfgFsInv = fInv;
    cfgBclkExt = 0; cfgFsExt = 0;
    doReset();
    total = n * frame * 2 + 3;
    for (int k = 1; k <= total; k++) begin
      int bitIdx;
      bit act;
      @(posedge mclk); #1;
      if (n == 1) begin
        bitIdx = (k - 1) % frame;
        check("R2 bclk follows mclk high", bclkOut, 1 ^ bInv);
      end else begin
        bitIdx = ((k - 1) / n) % frame;
        check("R1 divided bclk phase", bclkOut, (((k - 1) % n) < (n / 2)) ^ bInv);
      end
      act = wide ? (bitIdx < slotLen) : (bitIdx == 0);
      check(wide ? "R7 slot-wide fs R6 R8" : "R7 bit-wide fs R6 R8", fsOut, act ^ fInv);
      if (k == 1) begin
        check("R12 bclkOe internal", bclkOe, 1);
        check("R12 fsOe internal", fsOe, 1);
      end
      if (n == 1) begin
        @(negedge mclk); #1;
        check("R2 bclk follows mclk low R5", bclkOut, bInv);
      end
    end
  endtask

  initial begin
    int expSeq [9] = '{0, 0, 1, 1, 1, 0, 0, 0, 1};
    // sweep of ratios and frame shapes
    foreach (expSeq[i]) begin end
    for (int n = 1; n <= 7; n++) begin
      runInternal(n, 3, 2, 0, 0, 0);
      runInternal(n, 2, 3, 1, 1, 1);
    end
    runInternal(4096, 1, 2, 0, 0, 1);

    // R3: change ratio from 4 to 6 in mid period
    runInternal(4, 2, 2, 0, 0, 0);
    doReset();
    @(posedge mclk); @(posedge mclk); #1;
    cfgDivCode = 12'd5;
    for (int i = 0; i < 9; i++) begin
      @(posedge mclk); #1;
      check("R3 ratio change at terminal count", bclkOut, expSeq[i]);
    end
    cfgDivCode = 12'd3;

    // R4 R5 R9: external pass-through
    cfgBclkExt = 1; cfgFsExt = 1;
    for (int p = 0; p < 8; p++) begin
      cfgBclkInv = p[2]; cfgFsInv = p[2];
      extBclk = p[0]; extFs = p[1];
      #1;
      check("R4 R5 ext bclk", bclkOut, p[0] ^ p[2]);
      check("R9 R8 ext fs", fsOut, p[1] ^ p[2]);
      check("R4 bclkOe ext", bclkOe, 0);
      check("R9 fsOe ext", fsOe, 0);
    end

    // R10: external bit clock steps internal frame sync
    cfgFsExt = 0; cfgBclkInv = 0; cfgFsInv = 0; cfgFsSlotWide = 0;
    cfgSlotLenM1 = 5'd1; cfgSlotsM1 = 4'd1;
    extBclk = 0;
    doReset();
    for (int i = 0; i < 12; i++) begin
      @(negedge mclk); extBclk = 1;
      repeat (3) @(posedge mclk);
      #1;
      check("R10 fs with ext bclk", fsOut, (i % 4) == 0);
      @(negedge mclk); extBclk = 0;
      repeat (4) @(negedge mclk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule